// File: doc/BRIEF.md
# Banked Video Memory Access Unit

This block turns byte-wide host accesses into accesses on a video RAM that is organised as four byte planes and stored as 32-bit words. The host sees a 64 KiB window. A bank register selects which 64 KiB slice of the RAM the window covers. Three addressing schemes are supported:

- **Chain-4 linear:** the window byte address maps straight onto RAM bytes.
- **Odd/even interleaved:** one address bit picks the plane, and the remaining bits are spread across words.
- **Planar latched:** one host byte addresses a whole 32-bit word across all four planes.

Every translated address is compared against the RAM size before the RAM is touched, whichever scheme is active. This means a bank value that fits the linear scheme cannot reach past the end of the RAM once software switches to a scheme that scales the address. An out-of-range read returns 0xFF. An out-of-range write has no effect at all.

The RAM sits outside the block, behind a synchronous word port with per-lane byte enables. The block drives the word address, the byte enables and the replicated write byte in the cycle of the host request. Read data comes back from the RAM one clock later, and the block selects the wanted lane in that cycle. Planar reads also capture the full word into a latch. The latch is presented on an output for downstream pixel logic. Planar writes record the enabled planes in a sticky status vector.

Top module: `vmem_bank_port`

## Requirements
- R1: After a synchronous active-low reset, `host_rvalid` is 0, `host_rdata` is 0x00, `latch_word` is 0, `plane_touched` is 0 and the bank register is 0.
- R2: In chain-4 mode (`cfg_chain4`=1), the byte address is bank×65536 + `host_addr`. Its word is the byte address divided by 4, and its lane is the byte address modulo 4. A write changes only that lane, and only when `cfg_plane_en[lane]` is 1. A read returns that byte.
- R3: In odd/even mode (`cfg_chain4`=0, `cfg_odd_even`=1), the plane is {`cfg_read_map[1]`, linear address bit 0}, for both reads and writes. The byte address is ((linear address with bit 0 cleared) × 2) OR plane. A write happens only when `cfg_plane_en[plane]` is 1.
- R4: In planar latched mode (both mode bits 0), the word index is the linear address. A read returns lane `cfg_read_map` of that word. The same read loads the whole word into `latch_word`, which becomes visible one cycle after `host_rdata`. `latch_word` changes on no other event.
- R5: A planar write replaces byte lane p of the addressed word with `host_wdata` when `cfg_plane_en[p]` is 1. Each lane p whose enable bit is 0 keeps its old value.
- R6: When the translated byte address is at or above `RAM_BYTES` (for planar mode, word index × 4), a read returns 0xFF and leaves `latch_word` unchanged. A write under the same condition issues no RAM write and leaves `plane_touched` unchanged.
- R7: A write to the bank register stores `bank_wdata` ANDed with (`RAM_BYTES`/65536 − 1). This holds the same way in every mode.
- R8: `plane_touched` is sticky. Each in-range planar write ORs `cfg_plane_en` into it. Writes in the other modes leave it unchanged.
- R9: `host_rvalid` is 1 exactly in the cycle after a cycle with `host_re`=1 and `host_we`=0. When `host_we` and `host_re` are both 1, the write is performed and no read result is produced.
- R10: When `cfg_chain4` and `cfg_odd_even` are both 1, chain-4 addressing applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 16 | Byte offset inside the 64 KiB window |
| host_wdata | input | 8 | Write byte |
| host_we | input | 1 | Write request for this cycle |
| host_re | input | 1 | Read request for this cycle |
| host_rdata | output | 8 | Read result, valid when `host_rvalid` is 1 |
| host_rvalid | output | 1 | Read result valid, one cycle after the request |
| cfg_chain4 | input | 1 | Chain-4 linear mode select |
| cfg_odd_even | input | 1 | Odd/even mode select, used when chain-4 is 0 |
| cfg_read_map | input | 2 | Read plane select |
| cfg_plane_en | input | 4 | Plane write enables |
| bank_we | input | 1 | Bank register write strobe |
| bank_wdata | input | 16 | Bank register write value |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write (with `ram_en`) |
| ram_word_addr | output | RAM_AW-2 | RAM word address (16 bits at default) |
| ram_be | output | 4 | RAM byte-lane enables |
| ram_wdata | output | 32 | RAM write data, host byte in every lane |
| ram_rdata | input | 32 | RAM read word, one cycle after the access |
| latch_word | output | 32 | Planar read latch |
| plane_touched | output | 4 | Sticky record of planes written in planar mode |

## Verification
The following properties are checked on every cycle:

- The one-cycle read-valid timing.
- The 0xFF result for planar reads beyond the RAM.
- The absence of RAM writes for out-of-range planar writes.
- The single-lane byte enables in chain-4 and odd/even modes.
- The latch holding between reads.
- The monotonic growth of `plane_touched`.

Some behaviour can only be shown by the bench's scenarios, which check it against its own memory model:

- The actual address arithmetic of each mode.
- The bank masking.
- The merging of bytes under partial plane enables.
- The mode priority.
- The out-of-range behaviour after a bank set in one mode is reused in another.

// File: rtl/vmem_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the banked video memory access unit.
// Assumes the RAM is built from 32-bit words holding four byte planes.
package vmem_pkg;

    // Addressing scheme in force for the current access
    typedef enum logic [1:0] {
        MODE_PLANAR  = 2'd0,
        MODE_ODDEVEN = 2'd1,
        MODE_CHAIN4  = 2'd2
    } vmem_mode_e;

    // Value returned for reads that fall outside the RAM
    localparam logic [7:0] FILL_BYTE = 8'hFF;

    // Number of byte planes in one RAM word
    localparam int PLANES = 4;

    // Size of the host window in address bits
    localparam int WINDOW_AW = 16;

endpackage

// File: rtl/vmem_bank_reg.sv
`timescale 1ns/1ps
// Bank register: holds the 64 KiB slice selected for the host window.
// Assumes BANK_W = log2(RAM size) - 16. The stored value is the written
// value ANDed with a fixed mask, independent of any mode bit.
module vmem_bank_reg #(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_we,
    input  logic [15:0]       bank_wdata,
    output logic [BANK_W-1:0] bank_q
);

    localparam logic [15:0] BANK_MASK = 16'((1 << BANK_W) - 1);

    logic [15:0] masked;

    // Apply the fixed bank mask to the written value
    always_comb masked = bank_wdata & BANK_MASK;

    // Bank storage, cleared on reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_q <= '0;
        else if (bank_we)
            bank_q <= BANK_W'(masked);
    end

endmodule

// File: rtl/vmem_addr_xlate.sv
`timescale 1ns/1ps
// Address translation: decodes the mode, forms the translated byte address
// and range-checks it against the RAM size in every mode.
// Assumes RAM_BYTES is a power of two of at least 256 KiB.
module vmem_addr_xlate
    import vmem_pkg::*;
#(
    parameter int RAM_BYTES = 262144,
    localparam int RAM_AW   = $clog2(RAM_BYTES),
    localparam int BANK_W   = RAM_AW - WINDOW_AW,
    localparam int WORD_AW  = RAM_AW - 2
) (
    input  logic [BANK_W-1:0]    bank_q,
    input  logic [WINDOW_AW-1:0] host_addr,
    input  logic                 cfg_chain4,
    input  logic                 cfg_odd_even,
    input  logic [1:0]           cfg_read_map,
    output vmem_mode_e           mode,
    output logic [WORD_AW-1:0]   word_addr,
    output logic [1:0]           lane,
    output logic                 out_of_range
);

    localparam int EXT_W = RAM_AW + 2;

    logic [RAM_AW-1:0] lin_addr;
    logic [EXT_W-1:0]  byte_addr;
    logic [1:0]        oe_plane;

    // Mode decode, chain-4 has priority over odd/even
    always_comb begin
        if (cfg_chain4)
            mode = MODE_CHAIN4;
        else if (cfg_odd_even)
            mode = MODE_ODDEVEN;
        else
            mode = MODE_PLANAR;
    end

    // Linear window address and translated byte address per mode
    always_comb begin
        lin_addr = {bank_q, host_addr};
        oe_plane = {cfg_read_map[1], lin_addr[0]};
        unique case (mode)
            MODE_CHAIN4:  byte_addr = EXT_W'(lin_addr);
            MODE_ODDEVEN: byte_addr = ((EXT_W'(lin_addr) & ~EXT_W'(1)) << 1)
                                      | EXT_W'(oe_plane);
            default:      byte_addr = EXT_W'(lin_addr) << 2;
        endcase
    end

    // Range check and split into RAM word and byte lane
    always_comb begin
        out_of_range = (byte_addr >= EXT_W'(RAM_BYTES));
        word_addr    = byte_addr[RAM_AW-1:2];
        lane         = (mode == MODE_PLANAR) ? cfg_read_map : byte_addr[1:0];
    end

endmodule

// File: rtl/vmem_write_path.sv
`timescale 1ns/1ps
// Write path: forms per-lane byte enables from the plane enables and keeps
// the sticky planar plane-written status.
// Assumes out-of-range writes must leave RAM and status untouched.
module vmem_write_path
    import vmem_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [7:0]  host_wdata,
    input  logic [3:0]  cfg_plane_en,
    input  vmem_mode_e  mode,
    input  logic [1:0]  lane,
    input  logic        out_of_range,
    output logic [3:0]  ram_be,
    output logic [31:0] ram_wdata,
    output logic [3:0]  plane_touched
);

    // One enable and one data lane per plane
    for (genvar g = 0; g < PLANES; g++) begin : g_lane
        // Planar writes use the full plane mask, the others a single lane
        always_comb begin
            if (mode == MODE_PLANAR)
                ram_be[g] = cfg_plane_en[g];
            else
                ram_be[g] = (lane == 2'(g)) && cfg_plane_en[g];
            ram_wdata[g*8 +: 8] = host_wdata;
        end
    end

    // Sticky record of planes written by in-range planar writes
    always_ff @(posedge clk) begin
        if (!rst_n)
            plane_touched <= '0;
        else if (host_we && !out_of_range && mode == MODE_PLANAR)
            plane_touched <= plane_touched | cfg_plane_en;
    end

endmodule

// File: rtl/vmem_read_path.sv
`timescale 1ns/1ps
// Read path: remembers the lane and range result of a read request, selects
// the byte from the RAM word one cycle later and loads the planar latch.
// Assumes the RAM returns read data one clock after the access.
module vmem_read_path
    import vmem_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_re,
    input  logic        host_we,
    input  vmem_mode_e  mode,
    input  logic [1:0]  lane,
    input  logic        out_of_range,
    input  logic [31:0] ram_rdata,
    output logic [7:0]  host_rdata,
    output logic        host_rvalid,
    output logic [31:0] latch_word
);

    logic       pend_q;
    logic       oor_q;
    logic       planar_q;
    logic [1:0] lane_q;

    // Capture request attributes for the return cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            oor_q    <= 1'b0;
            planar_q <= 1'b0;
            lane_q   <= '0;
        end else begin
            pend_q   <= host_re && !host_we;
            oor_q    <= out_of_range;
            planar_q <= (mode == MODE_PLANAR);
            lane_q   <= lane;
        end
    end

    // Planar latch, loaded only by in-range planar reads
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_word <= '0;
        else if (pend_q && planar_q && !oor_q)
            latch_word <= ram_rdata;
    end

    // Byte selection with fill value for out-of-range reads
    always_comb begin
        host_rvalid = pend_q;
        if (!pend_q)
            host_rdata = 8'h00;
        else if (oor_q)
            host_rdata = FILL_BYTE;
        else
            host_rdata = ram_rdata[lane_q*8 +: 8];
    end

endmodule

// File: rtl/vmem_bank_port.sv
`timescale 1ns/1ps
// Banked video memory access unit: byte-wide host port onto a four-plane
// video RAM with chain-4, odd/even and planar latched addressing, a 64 KiB
// bank register and range checking after translation in every mode.
// Assumes an external synchronous RAM of 32-bit words with byte enables.
module vmem_bank_port
    import vmem_pkg::*;
#(
    parameter int RAM_BYTES = 262144,
    localparam int RAM_AW   = $clog2(RAM_BYTES),
    localparam int BANK_W   = RAM_AW - WINDOW_AW,
    localparam int WORD_AW  = RAM_AW - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [15:0]        host_addr,
    input  logic [7:0]         host_wdata,
    input  logic               host_we,
    input  logic               host_re,
    output logic [7:0]         host_rdata,
    output logic               host_rvalid,
    input  logic               cfg_chain4,
    input  logic               cfg_odd_even,
    input  logic [1:0]         cfg_read_map,
    input  logic [3:0]         cfg_plane_en,
    input  logic               bank_we,
    input  logic [15:0]        bank_wdata,
    output logic               ram_en,
    output logic               ram_we,
    output logic [WORD_AW-1:0] ram_word_addr,
    output logic [3:0]         ram_be,
    output logic [31:0]        ram_wdata,
    input  logic [31:0]        ram_rdata,
    output logic [31:0]        latch_word,
    output logic [3:0]         plane_touched
);

    logic [BANK_W-1:0]  bank_q;
    vmem_mode_e         mode;
    logic [WORD_AW-1:0] word_addr;
    logic [1:0]         lane;
    logic               out_of_range;

    vmem_bank_reg #(.BANK_W(BANK_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank_we    (bank_we),
        .bank_wdata (bank_wdata),
        .bank_q     (bank_q)
    );

    vmem_addr_xlate #(.RAM_BYTES(RAM_BYTES)) u_xlate (
        .bank_q       (bank_q),
        .host_addr    (host_addr),
        .cfg_chain4   (cfg_chain4),
        .cfg_odd_even (cfg_odd_even),
        .cfg_read_map (cfg_read_map),
        .mode         (mode),
        .word_addr    (word_addr),
        .lane         (lane),
        .out_of_range (out_of_range)
    );

    vmem_write_path u_wr (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_we       (host_we),
        .host_wdata    (host_wdata),
        .cfg_plane_en  (cfg_plane_en),
        .mode          (mode),
        .lane          (lane),
        .out_of_range  (out_of_range),
        .ram_be        (ram_be),
        .ram_wdata     (ram_wdata),
        .plane_touched (plane_touched)
    );

    vmem_read_path u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_re      (host_re),
        .host_we      (host_we),
        .mode         (mode),
        .lane         (lane),
        .out_of_range (out_of_range),
        .ram_rdata    (ram_rdata),
        .host_rdata   (host_rdata),
        .host_rvalid  (host_rvalid),
        .latch_word   (latch_word)
    );

    // RAM strobes: only in-range requests reach the RAM
    always_comb begin
        ram_en        = (host_we || host_re) && !out_of_range;
        ram_we        = host_we && !out_of_range;
        ram_word_addr = word_addr;
    end

endmodule

// File: rtl/vmem_bank_port_chk.sv
`timescale 1ns/1ps
// Property checker for vmem_bank_port, attached through bind.
// Assumes the bank register value is brought in from the top module.
module vmem_bank_port_chk #(
    parameter int RAM_BYTES = 262144,
    localparam int RAM_AW   = $clog2(RAM_BYTES),
    localparam int BANK_W   = RAM_AW - 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       host_addr,
    input logic              host_we,
    input logic              host_re,
    input logic [7:0]        host_rdata,
    input logic              host_rvalid,
    input logic              cfg_chain4,
    input logic              cfg_odd_even,
    input logic              ram_we,
    input logic [3:0]        ram_be,
    input logic [31:0]       latch_word,
    input logic [3:0]        plane_touched,
    input logic [BANK_W-1:0] bank_q
);

    logic past_ok;
    logic planar_mode;
    logic planar_oor;

    // Marks cycles whose previous sample lies after reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            past_ok <= 1'b0;
        else
            past_ok <= 1'b1;
    end

    // Independent view of planar mode and its range limit
    always_comb begin
        planar_mode = !cfg_chain4 && !cfg_odd_even;
        planar_oor  = ({bank_q, host_addr} >= RAM_AW'(RAM_BYTES / 4));
    end

    assert_rvalid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_re && !host_we) |=> host_rvalid);

    assert_rvalid_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && host_rvalid) |-> $past(host_re && !host_we));

    assert_planar_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_re && !host_we && planar_mode && planar_oor) |=> (host_rdata == 8'hFF));

    assert_planar_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && planar_mode && planar_oor) |-> !ram_we);

    assert_single_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && (cfg_chain4 || cfg_odd_even)) |-> $onehot0(ram_be));

    assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rvalid |=> $stable(latch_word));

    assert_touched_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((plane_touched & $past(plane_touched)) == $past(plane_touched)));

endmodule

bind vmem_bank_port vmem_bank_port_chk #(.RAM_BYTES(RAM_BYTES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_addr     (host_addr),
    .host_we       (host_we),
    .host_re       (host_re),
    .host_rdata    (host_rdata),
    .host_rvalid   (host_rvalid),
    .cfg_chain4    (cfg_chain4),
    .cfg_odd_even  (cfg_odd_even),
    .ram_we        (ram_we),
    .ram_be        (ram_be),
    .latch_word    (latch_word),
    .plane_touched (plane_touched),
    .bank_q        (bank_q)
);

// File: tb/vmem_bank_port_test.sv
`timescale 1ns/1ps
module vmem_bank_port_test;

    localparam int RAM_BYTES = 262144;
    localparam int WORDS     = RAM_BYTES / 4;
    localparam int BANK_MASK = (RAM_BYTES >> 16) - 1;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] host_addr;
    logic [7:0]  host_wdata;
    logic        host_we, host_re;
    logic [7:0]  host_rdata;
    logic        host_rvalid;
    logic        cfg_chain4, cfg_odd_even;
    logic [1:0]  cfg_read_map;
    logic [3:0]  cfg_plane_en;
    logic        bank_we;
    logic [15:0] bank_wdata;
    logic        ram_en, ram_we;
    logic [15:0] ram_word_addr;
    logic [3:0]  ram_be;
    logic [31:0] ram_wdata;
    logic [31:0] ram_rdata;
    logic [31:0] latch_word;
    logic [3:0]  plane_touched;

    logic [31:0] ram     [WORDS];
    logic [31:0] ref_mem [WORDS];
    int          ref_bank;
    logic [3:0]  ref_touched;
    logic [31:0] ref_latch;
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 0;

    always #2 clk = ~clk;

    vmem_bank_port #(.RAM_BYTES(RAM_BYTES)) uut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_we(host_we), .host_re(host_re), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .cfg_chain4(cfg_chain4), .cfg_odd_even(cfg_odd_even),
        .cfg_read_map(cfg_read_map), .cfg_plane_en(cfg_plane_en), .bank_we(bank_we),
        .bank_wdata(bank_wdata), .ram_en(ram_en), .ram_we(ram_we),
        .ram_word_addr(ram_word_addr), .ram_be(ram_be), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata), .latch_word(latch_word), .plane_touched(plane_touched)
    );

    // Synchronous RAM model with byte enables and one-cycle read
    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) begin
                for (int p = 0; p < 4; p++)
                    if (ram_be[p]) ram[ram_word_addr][p*8 +: 8] <= ram_wdata[p*8 +: 8];
            end else begin
                ram_rdata <= ram[ram_word_addr];
            end
        end
    end

    function automatic logic [31:0] init_val(int i);
        return (32'(i) * 32'h9E3779B1) ^ 32'h5A5A5A5A;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string mtag(int m);
        return (m == 0) ? "R5" : ((m == 1) ? "R3" : "R2");
    endfunction

    // Expected translation from the requirements (m: 0 planar, 1 odd/even, 2 chain-4)
    function automatic void xlate(input int m, input logic [15:0] a, input logic [1:0] rmap,
                                  output int word, output int lane, output bit oor);
        longint lin, b;
        lin = longint'(ref_bank) * 65536 + longint'(a);
        if (m == 2)      b = lin;
        else if (m == 1) b = ((lin & ~64'd1) << 1) | longint'({rmap[1], lin[0]});
        else             b = lin * 4;
        oor  = (b >= RAM_BYTES);
        word = oor ? 0 : int'(b / 4);
        lane = (m == 0) ? int'(rmap) : int'(b % 4);
    endfunction

    task automatic set_mode(int m, bit both);
        cfg_chain4   = (m == 2);
        cfg_odd_even = (m == 1) || (m == 2 && both);
    endtask

    task automatic bank_write(logic [15:0] v);
        bank_wdata = v;
        bank_we    = 1'b1;
        @(posedge clk); @(negedge clk);
        bank_we  = 1'b0;
        ref_bank = int'(v) & BANK_MASK;
    endtask

    task automatic host_write(int m, logic [15:0] a, logic [7:0] d, logic [3:0] pen,
                              logic [1:0] rmap, bit also_read);
        int word, lane; bit oor;
        xlate(m, a, rmap, word, lane, oor);
        host_addr = a; host_wdata = d; cfg_plane_en = pen; cfg_read_map = rmap;
        host_we = 1'b1; host_re = also_read;
        #1;
        chk(oor ? "R6" : mtag(m), "ram_we on write", 32'(ram_we), 32'(!oor));
        if (!oor) begin
            if (m == 0) begin
                for (int p = 0; p < 4; p++) if (pen[p]) ref_mem[word][p*8 +: 8] = d;
                ref_touched = ref_touched | pen;
            end else if (pen[lane]) begin
                ref_mem[word][lane*8 +: 8] = d;
            end
        end
        @(posedge clk); @(negedge clk);
        host_we = 1'b0; host_re = 1'b0;
        chk("R8", "plane_touched", 32'(plane_touched), 32'(ref_touched));
        chk("R9", "no rvalid after write", 32'(host_rvalid), 32'd0);
        if (!oor) chk(mtag(m), "RAM word after write", ram[word], ref_mem[word]);
    endtask

    task automatic host_read(int m, logic [15:0] a, logic [1:0] rmap);
        int word, lane; bit oor; logic [7:0] exp;
        xlate(m, a, rmap, word, lane, oor);
        exp = oor ? 8'hFF : ref_mem[word][lane*8 +: 8];
        host_addr = a; cfg_read_map = rmap; host_re = 1'b1; host_we = 1'b0;
        @(posedge clk); @(negedge clk);
        host_re = 1'b0;
        chk("R9", "rvalid after read", 32'(host_rvalid), 32'd1);
        chk(oor ? "R6" : ((m == 0) ? "R4" : mtag(m)), "read data", 32'(host_rdata), 32'(exp));
        if (m == 0 && !oor) ref_latch = ref_mem[word];
        @(posedge clk); @(negedge clk);
        chk(oor ? "R6" : "R4", "latch_word", latch_word, ref_latch);
        chk("R9", "rvalid drops", 32'(host_rvalid), 32'd0);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < WORDS; i++) begin
            ram[i] = init_val(i);
            ref_mem[i] = init_val(i);
        end
        rst_n = 1'b0; host_addr = '0; host_wdata = '0; host_we = 0; host_re = 0;
        cfg_chain4 = 0; cfg_odd_even = 0; cfg_read_map = 0; cfg_plane_en = 0;
        bank_we = 0; bank_wdata = 0; ram_rdata = '0;
        ref_bank = 0; ref_touched = 0; ref_latch = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1", "rvalid", 32'(host_rvalid), 32'd0);
        chk("R1", "rdata", 32'(host_rdata), 32'd0);
        chk("R1", "latch", latch_word, 32'd0);
        chk("R1", "plane_touched", 32'(plane_touched), 32'd0);
        set_mode(2, 0);
        host_read(2, 16'h0007, 2'd0);   // R1 bank 0 selects slice 0

        // R2 chain-4 writes with full and partial plane enables
        host_write(2, 16'h1235, 8'h3C, 4'hF, 2'd0, 0);
        host_read(2, 16'h1235, 2'd0);
        host_write(2, 16'h1236, 8'h77, 4'b1011, 2'd0, 0);  // lane 2 disabled
        host_read(2, 16'h1236, 2'd0);

        // R3 odd/even with both read-map high bits
        set_mode(1, 0);
        host_write(1, 16'h0005, 8'hA1, 4'hF, 2'd2, 0);
        host_read(1, 16'h0005, 2'd2);
        host_write(1, 16'h0004, 8'hB2, 4'b1110, 2'd0, 0);  // plane 0 disabled
        host_read(1, 16'h0004, 2'd0);

        // R4 R5 planar partial merge, all read lanes
        set_mode(0, 0);
        host_write(0, 16'h0010, 8'hC3, 4'b0101, 2'd0, 0);
        for (int r = 0; r < 4; r++) host_read(0, 16'h0010, 2'(r));

        // R7 bank mask, R6 planar beyond RAM
        bank_write(16'hFFFF);
        host_read(0, 16'h0000, 2'd1);
        host_write(0, 16'h0100, 8'h55, 4'hF, 2'd0, 0);
        // R6 the same bank stays legal in chain-4, overflows in odd/even
        set_mode(2, 0);
        host_write(2, 16'hFFFF, 8'h99, 4'hF, 2'd0, 0);
        host_read(2, 16'hFFFF, 2'd0);
        set_mode(1, 0);
        host_read(1, 16'h8000, 2'd0);
        host_write(1, 16'h8001, 8'h66, 4'hF, 2'd2, 0);
        bank_write(16'h0001);

        // R10 both mode bits set picks chain-4
        set_mode(2, 1);
        host_write(2, 16'h0042, 8'hE7, 4'hF, 2'd0, 0);
        host_read(2, 16'h0042, 2'd0);

        // R9 simultaneous write and read performs the write only
        host_write(2, 16'h0043, 8'h18, 4'hF, 2'd0, 1);
        host_read(2, 16'h0043, 2'd0);

        // Constrained random mix
        for (int n = 0; n < 2500; n++) begin
            int op, m; logic [15:0] a;
            op = int'($urandom_range(0, 9));
            m  = int'($urandom_range(0, 2));
            a  = ($urandom_range(0, 1) == 1) ? 16'($urandom) : 16'($urandom & 32'h3F);
            set_mode(m, 1'($urandom));
            if (op == 0)      bank_write(16'($urandom));
            else if (op < 5)  host_write(m, a, 8'($urandom), 4'($urandom), 2'($urandom), 0);
            else              host_read(m, a, 2'($urandom));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule